// File: doc/BRIEF.md
# Broadcast Stream Input Switch

This block sits between a single streaming read channel and a group of accelerator ports. It takes one valid/ready data stream with an end-of-packet flag and passes each beat on to a set of output ports. Software picks that set through a small configuration write port, as a destination mask with one bit per output. When one bit is set, the stream goes to one accelerator. When several bits are set, the same beat goes to all of them at once.

The switch stores no payload. A beat is taken from the input only in a cycle where every selected output can take it. Each selected output then sees the beat exactly once. If the mask is written while a packet is under way, the change waits until the packet's final beat has been accepted, so a packet is never split across two destination sets. The current mask and a packet-in-progress flag can be read on two outputs.

Top module: `cis_bcast_switch`

## Requirements
- R1: After reset the active mask is all zeros, no packet is in progress, and no output valid is asserted.
- R2: A mask write while no packet is in progress (and no non-final beat is accepted in that cycle) appears on `act_mask` in the next cycle.
- R3: With exactly one mask bit set, `s_ready` equals that port's `m_ready`, and only that port's `m_valid` can assert, together with `s_valid` and `s_ready`.
- R4: With several mask bits set, `s_ready` is the AND of the selected ports' `m_ready`. Every selected `m_valid` asserts in the same cycle, only when `s_valid` and `s_ready` are both high, so no port receives a beat twice.
- R5: Ports whose mask bit is 0 never assert `m_valid`, and their `m_ready` has no effect on `s_ready`.
- R6: Each port's data slice `m_data[i*DATA_W +: DATA_W]` and `m_last[i]` equal `s_data` and `s_last` whenever that port's `m_valid` is high.
- R7: With an all-zero mask, `s_ready` is 1 and no `m_valid` asserts, so incoming beats are discarded.
- R8: `pkt_busy` goes to 1 in the cycle after a beat with `s_last`=0 is accepted, and goes to 0 in the cycle after a beat with `s_last`=1 is accepted.
- R9: A mask write while a packet is in progress is held back. It takes effect in the cycle after the final beat is accepted, and if several writes arrive during the packet, the last one wins.
- R10: A mask write in the same cycle as the acceptance of a packet's first, non-final beat is held back in the same way as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Destination mask write strobe |
| cfg_mask | input | NUM_PORTS | Destination mask to write, one bit per output |
| s_valid | input | 1 | Input beat valid |
| s_data | input | DATA_W | Input beat payload |
| s_last | input | 1 | Input beat is the last of its packet |
| s_ready | output | 1 | Input beat accepted this cycle when high with s_valid |
| m_valid | output | NUM_PORTS | Per-port beat valid |
| m_data | output | NUM_PORTS*DATA_W | Per-port payload, port i in slice i*DATA_W |
| m_last | output | NUM_PORTS | Per-port last flag |
| m_ready | input | NUM_PORTS | Per-port ready |
| pkt_busy | output | 1 | A packet is in progress |
| act_mask | output | NUM_PORTS | Destination mask currently in force |

## Verification
The assertions assume that the upstream source keeps `s_valid` and the downstream ports keep `m_ready` free of any combinational dependence on this block's outputs. The output valids depend on the joined readies, so a ready that waits for valid would form a loop. The bench drives `m_ready` and `s_valid` independently, from directed patterns and from random values chosen before each cycle. It never derives them from `m_valid` or `s_ready`. The bench also applies mask writes at arbitrary points inside packets, including the cycle of the first accepted beat. It does this without ever requiring the upstream to hold a beat stable, because the switch makes no assumption about that.

// File: rtl/cis_pkg.sv
package cis_pkg;

    // Packet framing state seen by the input side of the switch.
    typedef enum logic {
        PKT_IDLE   = 1'b0,
        PKT_ACTIVE = 1'b1
    } pkt_state_e;

    // Upper bound on the port count supported by the mask encoding.
    localparam int unsigned CIS_MAX_PORTS = 16;

endpackage

// File: rtl/cis_pkt_track.sv
module cis_pkt_track
    import cis_pkg::*;
(
    input  logic clk,
    input  logic rst_ni,
    input  logic beat_fire,
    input  logic beat_last,
    output logic busy_q,
    output logic busy_d
);

    typedef struct packed {
        pkt_state_e state;
    } trk_state_t;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (beat_fire) begin
            st_d.state = beat_last ? PKT_IDLE : PKT_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{state: PKT_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_q = (st_q.state == PKT_ACTIVE);
    assign busy_d = (st_d.state == PKT_ACTIVE);

    AST_LAST_ENDS_PKT: assert property (@(posedge clk) disable iff (!rst_ni)
        beat_fire && beat_last |=> !busy_q); // R8

    AST_BODY_OPENS_PKT: assert property (@(posedge clk) disable iff (!rst_ni)
        beat_fire && !beat_last |=> busy_q); // R8

    AST_IDLE_WITHOUT_BEAT: assert property (@(posedge clk) disable iff (!rst_ni)
        !busy_q && !beat_fire |=> !busy_q); // R8

endmodule

// File: rtl/cis_cfg_reg.sv
module cis_cfg_reg #(
    parameter int unsigned NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_ni,
    input  logic                 wr_en,
    input  logic [NUM_PORTS-1:0] wr_mask,
    input  logic                 busy_next,
    output logic [NUM_PORTS-1:0] act_q
);

    typedef struct packed {
        logic [NUM_PORTS-1:0] act;
        logic [NUM_PORTS-1:0] held;
        logic                 held_vld;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (busy_next) begin
                // Packet still open after this cycle: park the value.
                st_d.held     = wr_mask;
                st_d.held_vld = 1'b1;
            end else begin
                st_d.act      = wr_mask;
                st_d.held_vld = 1'b0;
            end
        end else if (!busy_next) begin
            if (st_q.held_vld) begin
                st_d.act = st_q.held;
            end
            st_d.held_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{act: '0, held: '0, held_vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_q = st_q.act;

    AST_HOLD_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_ni)
        busy_next |=> $stable(act_q)); // R9

    AST_HELD_ONLY_IN_PKT: assert property (@(posedge clk) disable iff (!rst_ni)
        !busy_next |=> !st_q.held_vld); // R9

endmodule

// File: rtl/cis_fanout.sv
module cis_fanout #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_ni,
    input  logic [NUM_PORTS-1:0]          sel,
    input  logic                          s_valid,
    input  logic [DATA_W-1:0]             s_data,
    input  logic                          s_last,
    output logic                          s_ready,
    output logic [NUM_PORTS-1:0]          m_valid,
    output logic [NUM_PORTS*DATA_W-1:0]   m_data,
    output logic [NUM_PORTS-1:0]          m_last,
    input  logic [NUM_PORTS-1:0]          m_ready,
    output logic                          beat_fire
);

    logic [NUM_PORTS-1:0] port_ok;
    logic                 join_rdy;

    // A port blocks the join only when it is selected and not ready.
    assign port_ok   = m_ready | ~sel;
    assign join_rdy  = &port_ok;
    assign s_ready   = join_rdy;
    assign beat_fire = s_valid && join_rdy;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign m_valid[p]                   = beat_fire && sel[p];
        assign m_data[p*DATA_W +: DATA_W]   = s_data;
        assign m_last[p]                    = s_last;

        AST_PORT_SEES_INPUT: assert property (@(posedge clk) disable iff (!rst_ni)
            m_valid[p] |-> (m_data[p*DATA_W +: DATA_W] == s_data) && (m_last[p] == s_last)); // R6

        AST_PORT_READY_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
            m_valid[p] |-> m_ready[p]); // R4
    end

endmodule

// File: rtl/cis_bcast_switch.sv
module cis_bcast_switch #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_ni,
    input  logic                        cfg_we,
    input  logic [NUM_PORTS-1:0]        cfg_mask,
    input  logic                        s_valid,
    input  logic [DATA_W-1:0]           s_data,
    input  logic                        s_last,
    output logic                        s_ready,
    output logic [NUM_PORTS-1:0]        m_valid,
    output logic [NUM_PORTS*DATA_W-1:0] m_data,
    output logic [NUM_PORTS-1:0]        m_last,
    input  logic [NUM_PORTS-1:0]        m_ready,
    output logic                        pkt_busy,
    output logic [NUM_PORTS-1:0]        act_mask
);

    localparam int unsigned MASK_W = NUM_PORTS;

    logic              beat_fire;
    logic              busy_q;
    logic              busy_d;
    logic [MASK_W-1:0] sel_q;

    cis_pkt_track i_track (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .beat_fire (beat_fire),
        .beat_last (s_last),
        .busy_q    (busy_q),
        .busy_d    (busy_d)
    );

    cis_cfg_reg #(.NUM_PORTS(NUM_PORTS)) i_cfg (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .wr_en     (cfg_we),
        .wr_mask   (cfg_mask),
        .busy_next (busy_d),
        .act_q     (sel_q)
    );

    cis_fanout #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) i_fan (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .sel       (sel_q),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .m_valid   (m_valid),
        .m_data    (m_data),
        .m_last    (m_last),
        .m_ready   (m_ready),
        .beat_fire (beat_fire)
    );

    assign pkt_busy = busy_q;
    assign act_mask = sel_q;

    AST_DROP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
        (act_mask == '0) |-> s_ready && (m_valid == '0)); // R7

    AST_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_ni)
        (s_valid && s_ready) |-> (m_valid == act_mask)); // R4

    AST_NO_VALID_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_ni)
        (m_valid & ~act_mask) == '0); // R5

    AST_VALID_IMPLIES_ACCEPT: assert property (@(posedge clk) disable iff (!rst_ni)
        (m_valid != '0) |-> s_valid && s_ready); // R3

    AST_MASK_FROZEN_IN_PKT: assert property (@(posedge clk) disable iff (!rst_ni)
        pkt_busy && !(s_valid && s_ready && s_last) |=> $stable(act_mask)); // R9

    AST_FIRST_BEAT_FREEZES: assert property (@(posedge clk) disable iff (!rst_ni)
        !pkt_busy && s_valid && s_ready && !s_last |=> $stable(act_mask)); // R10

    AST_IDLE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_ni)
        cfg_we && !pkt_busy && !(s_valid && s_ready && !s_last) |=> act_mask == $past(cfg_mask)); // R2

endmodule

// File: tb/test_cis_bcast_switch.sv
module test_cis_bcast_switch;

    localparam int NP = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_ni;
    logic             cfg_we;
    logic [NP-1:0]    cfg_mask;
    logic             s_valid;
    logic [DW-1:0]    s_data;
    logic             s_last;
    logic             s_ready;
    logic [NP-1:0]    m_valid;
    logic [NP*DW-1:0] m_data;
    logic [NP-1:0]    m_last;
    logic [NP-1:0]    m_ready;
    logic             pkt_busy;
    logic [NP-1:0]    act_mask;

    cis_bcast_switch #(.NUM_PORTS(NP), .DATA_W(DW)) i_cis_bcast_switch (
        .clk      (clk),
        .rst_ni   (rst_ni),
        .cfg_we   (cfg_we),
        .cfg_mask (cfg_mask),
        .s_valid  (s_valid),
        .s_data   (s_data),
        .s_last   (s_last),
        .s_ready  (s_ready),
        .m_valid  (m_valid),
        .m_data   (m_data),
        .m_last   (m_last),
        .m_ready  (m_ready),
        .pkt_busy (pkt_busy),
        .act_mask (act_mask)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [NP-1:0] md_act;
    logic [NP-1:0] md_held;
    bit            md_held_vld;
    bit            md_busy;

    task automatic chk(input string tag, input logic [63:0] actual, input logic [63:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
        end
    endtask

    task automatic cycle(input bit we, input logic [NP-1:0] wm, input bit v,
                         input logic [DW-1:0] d, input bit l, input logic [NP-1:0] r);
        bit            exp_rdy;
        logic [NP-1:0] exp_vld;
        string         tag;
        bit            fire;
        bit            busy_n;
        @(negedge clk);
        cfg_we = we; cfg_mask = wm; s_valid = v; s_data = d; s_last = l; m_ready = r;
        #1;
        exp_rdy = 1'b1;
        for (int i = 0; i < NP; i++) if (md_act[i] && !r[i]) exp_rdy = 1'b0;
        for (int i = 0; i < NP; i++) exp_vld[i] = v && md_act[i] && exp_rdy;
        if (md_act == '0)             tag = "R7";
        else if ($countones(md_act) == 1) tag = "R3";
        else                          tag = "R4";
        chk("R2/R9 act_mask", 64'(act_mask), 64'(md_act));
        chk("R8 pkt_busy", 64'(pkt_busy), 64'(md_busy));
        chk({tag, " s_ready"}, 64'(s_ready), 64'(exp_rdy));
        chk({tag, " m_valid"}, 64'(m_valid & md_act), 64'(exp_vld));
        chk("R5 unselected m_valid", 64'(m_valid & ~md_act), 64'd0);
        for (int i = 0; i < NP; i++) begin
            if (exp_vld[i]) begin
                chk("R6 data", 64'(m_data[i*DW +: DW]), 64'(d));
                chk("R6 last", 64'(m_last[i]), 64'(l));
            end
        end
        fire   = v && exp_rdy;
        busy_n = fire ? !l : md_busy;
        @(posedge clk);
        if (we) begin
            if (busy_n) begin md_held = wm; md_held_vld = 1'b1; end
            else begin md_act = wm; md_held_vld = 1'b0; end
        end else if (!busy_n) begin
            if (md_held_vld) md_act = md_held;
            md_held_vld = 1'b0;
        end
        md_busy = busy_n;
    endtask

    task automatic idle_cycle(input logic [NP-1:0] r);
        cycle(1'b0, '0, 1'b0, '0, 1'b0, r);
    endtask

    initial begin
        rst_ni = 1'b0; cfg_we = 1'b0; cfg_mask = '0; s_valid = 1'b0;
        s_data = '0; s_last = 1'b0; m_ready = '0;
        md_act = '0; md_held = '0; md_held_vld = 1'b0; md_busy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 act_mask", 64'(act_mask), 64'd0);
        chk("R1 pkt_busy", 64'(pkt_busy), 64'd0);
        chk("R1 m_valid", 64'(m_valid), 64'd0);
        rst_ni = 1'b1;

        // R2 idle write, then R3 single port with toggling ready and R5 others low
        cycle(1'b1, 4'b0001, 1'b0, '0, 1'b0, '0);
        cycle(1'b0, '0, 1'b1, 32'hA0, 1'b0, 4'b0000);
        cycle(1'b0, '0, 1'b1, 32'hA0, 1'b0, 4'b0001);
        cycle(1'b0, '0, 1'b1, 32'hA1, 1'b0, 4'b1110);
        cycle(1'b0, '0, 1'b1, 32'hA1, 1'b0, 4'b0001);
        cycle(1'b0, '0, 1'b1, 32'hA2, 1'b1, 4'b0001);

        // R4 broadcast with staggered readiness
        cycle(1'b1, 4'b1011, 1'b0, '0, 1'b0, '0);
        cycle(1'b0, '0, 1'b1, 32'hB0, 1'b0, 4'b0011);
        cycle(1'b0, '0, 1'b1, 32'hB0, 1'b0, 4'b1010);
        cycle(1'b0, '0, 1'b1, 32'hB0, 1'b0, 4'b1011);
        cycle(1'b0, '0, 1'b1, 32'hB1, 1'b1, 4'b1111);

        // R7 zero mask drops beats
        cycle(1'b1, 4'b0000, 1'b0, '0, 1'b0, '0);
        cycle(1'b0, '0, 1'b1, 32'hC0, 1'b0, 4'b0000);
        cycle(1'b0, '0, 1'b1, 32'hC1, 1'b1, 4'b1111);

        // R9 writes mid-packet are held; the last one wins after the final beat
        cycle(1'b1, 4'b0010, 1'b0, '0, 1'b0, '0);
        cycle(1'b0, '0, 1'b1, 32'hD0, 1'b0, 4'b1111);
        cycle(1'b1, 4'b0100, 1'b1, 32'hD1, 1'b0, 4'b0000);
        cycle(1'b1, 4'b1000, 1'b0, '0, 1'b0, 4'b1111);
        idle_cycle(4'b1111);
        chk("R9 held during packet", 64'(act_mask), 64'h2);
        cycle(1'b0, '0, 1'b1, 32'hD2, 1'b1, 4'b0010);
        #1 chk("R9 applied after last", 64'(act_mask), 64'h8);

        // R10 write together with first non-final beat is held
        cycle(1'b1, 4'b0001, 1'b0, '0, 1'b0, '0);
        cycle(1'b1, 4'b0110, 1'b1, 32'hE0, 1'b0, 4'b1111);
        #1 chk("R10 deferred", 64'(act_mask), 64'h1);
        cycle(1'b0, '0, 1'b1, 32'hE1, 1'b1, 4'b1111);
        #1 chk("R10 applied", 64'(act_mask), 64'h6);

        // Random traffic, compared every cycle against the model
        for (int n = 0; n < 4000; n++) begin
            bit            we = ($urandom_range(0, 9) == 0);
            logic [NP-1:0] wm = NP'($urandom);
            bit            v  = ($urandom_range(0, 3) != 0);
            logic [DW-1:0] d  = DW'($urandom);
            bit            l  = ($urandom_range(0, 3) == 0);
            logic [NP-1:0] r  = NP'($urandom) | NP'($urandom);
            cycle(we, wm, v, d, l, r);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule